// File: doc/BRIEF.md
# Page Table File Transfer Sequencer

This block keeps a bank of page-table maps in local storage and moves entries between that bank and byte-wide memory on command. One command carries a 3-bit selector, a control byte and a 16-bit starting memory address. The control byte names the target map and carries a 5-bit field. Depending on the selector, that field is a count or an entry index.

The selector chooses the direction and the shape of the run. The even selectors move bytes from memory into the map. The odd selectors move map entries out to memory. A run is one of three shapes: a counted run that begins at entry 0, a single entry at the given index, or the tail of the map from the given index through the last entry. On every transfer out to memory, bit 7 of each byte is replaced by a status bit taken from an input. Memory traffic uses a request/acknowledge handshake. The block raises `busy` while it works and pulses `done` when it finishes.

Top module: `page_file_xfer`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err` and `mem_req` are all 0.
- R2: Bits [2:0] of `cmd_ctrl` select one of 8 maps of 32 eight-bit entries. A transfer touches only the selected map.
- R3: Selector 0 loads N = `cmd_ctrl[7:3]` entries, from entry 0 upward, out of memory bytes at `cmd_addr`, `cmd_addr`+1, and so on. When N = 0 there is no memory access and `done` follows at once.
- R4: Selector 1 stores N = `cmd_ctrl[7:3]` entries, from entry 0 upward, to consecutive memory bytes starting at `cmd_addr`. Each written byte is {`status_bit`, entry[6:0]}.
- R5: Selector 2 loads, and selector 3 stores, exactly one entry at index `cmd_ctrl[7:3]`. The store also forces bit 7 to `status_bit`.
- R6: Selector 4 loads, and selector 5 stores, entries from index `cmd_ctrl[7:3]` through entry 31. That is 32 minus the index transfers. The store also forces bit 7 to `status_bit`.
- R7: Selectors 6 and 7 make no memory access. They pulse `done` and `err` together for one cycle. `err` is never high without `done`.
- R8: While `busy` is high, `cmd_valid` is ignored. This holds even in the cycle of the final acknowledge.
- R9: `mem_req` stays high, with `mem_addr` and `mem_we` stable, until `mem_ack` is seen. `mem_we` = 1 marks a store to memory. Addresses rise by one per entry.
- R10: `busy` stays high until the last entry is acknowledged. `busy` falls in the same cycle that `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; accepted only when idle |
| cmd_sel | input | 3 | Transfer selector 0..7 |
| cmd_ctrl | input | 8 | [2:0] map, [7:3] count or index |
| cmd_addr | input | 16 | First memory byte address |
| status_bit | input | 1 | Value forced into bit 7 on stores to memory |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rdata | input | 8 | Byte returned by memory, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Reserved selector; pulses together with `done` |

## Verification
Two events can fall in the same clock edge: the acknowledge of the final entry and the arrival of a new command. The bench provokes this by holding a different command (a full-length load into a neighbouring map) on `cmd_valid` for the whole of a transfer, through the very edge that ends it. The intruding command is withdrawn only once `done` is observed. It is judged ignored if three things hold: the memory responder counted exactly the expected number of transfers, every request address followed the expected sequence, and a later full read-back of the neighbouring map matches its model unchanged.

// File: rtl/ptf_pkg.sv
package ptf_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ADDR  = 2'd1,
    W_ISSUE = 2'd2,
    W_WAIT  = 2'd3
  } walk_state_t;

  // selector bits [2:1] give the run shape, bit 0 the direction
  typedef enum logic [1:0] {
    K_COUNTED = 2'b00,
    K_SINGLE  = 2'b01,
    K_TAIL    = 2'b10,
    K_RSVD    = 2'b11
  } run_kind_t;
endpackage

// File: rtl/ptf_cmd_decode.sv
module ptf_cmd_decode
  import ptf_pkg::*;
#(
  parameter int MAP_W       = 3,
  parameter int IDX_W       = 5,
  parameter int ENTRY_COUNT = 32
) (
  input  logic [SEL_W-1:0]       sel,
  input  logic [MAP_W+IDX_W-1:0] ctrl,
  output logic [MAP_W-1:0]       map,
  output logic [IDX_W-1:0]       start,
  output logic [IDX_W:0]         count,
  output logic                   to_mem,
  output logic                   rsvd
);
  logic [IDX_W-1:0] field;
  run_kind_t        kind;

  always_comb begin
    field  = ctrl[MAP_W+IDX_W-1:MAP_W];
    map    = ctrl[MAP_W-1:0];
    to_mem = sel[0];
    kind   = run_kind_t'(sel[2:1]);
    rsvd   = 1'b0;
    start  = '0;
    count  = '0;
    case (kind)
      K_COUNTED: count = {1'b0, field};
      K_SINGLE: begin
        start = field;
        count = (IDX_W+1)'(1);
      end
      K_TAIL: begin
        start = field;
        count = (IDX_W+1)'(ENTRY_COUNT) - {1'b0, field};
      end
      default: rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/ptf_table_ram.sv
module ptf_table_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/ptf_walker.sv
module ptf_walker
  import ptf_pkg::*;
#(
  parameter int MAP_W  = 3,
  parameter int IDX_W  = 5,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [MAP_W-1:0]       dec_map,
  input  logic [IDX_W-1:0]       dec_start,
  input  logic [IDX_W:0]         dec_count,
  input  logic                   dec_to_mem,
  input  logic                   dec_rsvd,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic                   status_bit,
  input  logic [DATA_W-1:0]      ram_q,
  output logic                   ram_we,
  output logic [MAP_W+IDX_W-1:0] ram_addr,
  output logic [DATA_W-1:0]      ram_wdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   mem_ack,
  output logic                   busy,
  output logic                   done,
  output logic                   err
);
  walk_state_t      state;
  logic [MAP_W-1:0] map_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W:0]   left_q;
  logic             to_mem_q;

  assign ram_addr  = {map_q, idx_q};
  assign ram_we    = (state == W_WAIT) && mem_ack && !to_mem_q;
  assign ram_wdata = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= W_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      map_q     <= '0;
      idx_q     <= '0;
      left_q    <= '0;
      to_mem_q  <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        W_IDLE: begin
          if (cmd_valid) begin
            if (dec_rsvd) begin
              done <= 1'b1;
              err  <= 1'b1;
            end else if (dec_count == '0) begin
              done <= 1'b1;
            end else begin
              busy     <= 1'b1;
              map_q    <= dec_map;
              idx_q    <= dec_start;
              left_q   <= dec_count;
              to_mem_q <= dec_to_mem;
              mem_addr <= cmd_addr;
              state    <= W_ADDR;
            end
          end
        end
        W_ADDR: state <= W_ISSUE;  // table read address settles
        W_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= to_mem_q;
          mem_wdata <= {status_bit, ram_q[DATA_W-2:0]};
          state     <= W_WAIT;
        end
        W_WAIT: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            idx_q   <= idx_q + 1'b1;
            left_q  <= left_q - 1'b1;
            if (left_q == (IDX_W+1)'(1)) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= W_IDLE;
            end else begin
              mem_addr <= mem_addr + 1'b1;
              state    <= W_ADDR;
            end
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_file_xfer.sv
module page_file_xfer
  import ptf_pkg::*;
#(
  parameter int MAP_COUNT   = 8,
  parameter int ENTRY_COUNT = 32,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 16
) (
  input  logic                                             clk,
  input  logic                                             rst,
  input  logic                                             cmd_valid,
  input  logic [2:0]                                       cmd_sel,
  input  logic [$clog2(MAP_COUNT)+$clog2(ENTRY_COUNT)-1:0] cmd_ctrl,
  input  logic [ADDR_W-1:0]                                cmd_addr,
  input  logic                                             status_bit,
  output logic                                             mem_req,
  output logic                                             mem_we,
  output logic [ADDR_W-1:0]                                mem_addr,
  output logic [DATA_W-1:0]                                mem_wdata,
  input  logic [DATA_W-1:0]                                mem_rdata,
  input  logic                                             mem_ack,
  output logic                                             busy,
  output logic                                             done,
  output logic                                             err
);
  localparam int MAP_W = $clog2(MAP_COUNT);
  localparam int IDX_W = $clog2(ENTRY_COUNT);
  localparam int TAB_W = MAP_W + IDX_W;

  logic [MAP_W-1:0]  dec_map;
  logic [IDX_W-1:0]  dec_start;
  logic [IDX_W:0]    dec_count;
  logic              dec_to_mem;
  logic              dec_rsvd;
  logic              ram_we;
  logic [TAB_W-1:0]  ram_addr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_q;

  ptf_cmd_decode #(
    .MAP_W(MAP_W), .IDX_W(IDX_W), .ENTRY_COUNT(ENTRY_COUNT)
  ) u_decode (
    .sel(cmd_sel), .ctrl(cmd_ctrl), .map(dec_map), .start(dec_start),
    .count(dec_count), .to_mem(dec_to_mem), .rsvd(dec_rsvd)
  );

  ptf_table_ram #(
    .AW(TAB_W), .DW(DATA_W)
  ) u_table (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  ptf_walker #(
    .MAP_W(MAP_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_walker (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid),
    .dec_map(dec_map), .dec_start(dec_start), .dec_count(dec_count),
    .dec_to_mem(dec_to_mem), .dec_rsvd(dec_rsvd),
    .cmd_addr(cmd_addr), .status_bit(status_bit), .ram_q(ram_q),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(busy), .done(done), .err(err)
  );
endmodule

// File: rtl/page_file_xfer_chk.sv
module page_file_xfer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              busy,
  input logic              done,
  input logic              err
);
  // R1: no memory traffic outside a transfer
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R9: a pending request holds its address and direction
  a_r9_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R10: leaving busy coincides with the done pulse
  a_r10_done_on_finish: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R7: err only accompanies done, never during a transfer
  a_r7_err_only_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !busy));

  // R8: a new request never starts in the cycle that completion is signalled
  a_r8_no_req_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
endmodule

bind page_file_xfer page_file_xfer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .busy(busy), .done(done), .err(err)
);

// File: tb/page_file_xfer_bench.sv
module page_file_xfer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [2:0]  cmd_sel;
  logic [7:0]  cmd_ctrl;
  logic [15:0] cmd_addr;
  logic        status_bit;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        busy, done, err;

  int checks = 0;
  int failures = 0;
  int ntx;
  int wait_cnt;
  logic [15:0] exp_addr;
  bit addr_bad;
  logic [7:0] bmem [256];
  logic [7:0] exp_tab [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_file_xfer u_page_file_xfer (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_ctrl(cmd_ctrl), .cmd_addr(cmd_addr), .status_bit(status_bit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input logic [2:0] sel, input logic [7:0] ctrl);
    case (sel)
      3'd0, 3'd1: return int'(ctrl[7:3]);
      3'd2, 3'd3: return 1;
      3'd4, 3'd5: return 32 - int'(ctrl[7:3]);
      default:    return 0;
    endcase
  endfunction

  function automatic int exp_start(input logic [2:0] sel, input logic [7:0] ctrl);
    return (sel == 3'd0 || sel == 3'd1) ? 0 : int'(ctrl[7:3]);
  endfunction

  function automatic string tag_of(input logic [2:0] sel);
    case (sel)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2, 3'd3: return "R5";
      3'd4, 3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  // memory responder: random latency, one-cycle acknowledge
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt > 0) wait_cnt--;
        else begin
          mem_ack = 1'b1;
          ntx++;
          if (mem_addr !== exp_addr) addr_bad = 1'b1;
          exp_addr = exp_addr + 16'd1;
          if (mem_we) bmem[mem_addr[7:0]] = mem_wdata;
          else mem_rdata = bmem[mem_addr[7:0]];
          wait_cnt = $urandom % 3;
        end
      end
    end
  end

  task automatic run_cmd(input logic [2:0] sel, input logic [7:0] ctrl,
                         input logic [15:0] addr, input logic st,
                         input bit intrude, input string tag);
    int n, start, map;
    bit got;
    logic e;
    n = exp_count(sel, ctrl);
    start = exp_start(sel, ctrl);
    map = int'(ctrl[2:0]);
    if (sel < 3'd6 && !sel[0])
      for (int i = 0; i < n; i++) bmem[(int'(addr) + i) & 255] = 8'($urandom);
    ntx = 0;
    exp_addr = addr;
    addr_bad = 1'b0;
    status_bit = st;
    got = 1'b0;
    e = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_sel = sel;
    cmd_ctrl = ctrl;
    cmd_addr = addr;
    @(negedge clk);
    if (intrude) begin
      chk(busy === 1'b1, "R8", int'(busy), 1);
      cmd_sel = 3'd0;
      cmd_ctrl = {5'd31, ctrl[2:0] ^ 3'd1};
      cmd_addr = addr + 16'd100;
    end else cmd_valid = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      if (done === 1'b1) begin
        got = 1'b1;
        e = err;
        break;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(got, "R10", int'(got), 1);
    chk(e === (sel >= 3'd6), "R7", int'(e), int'(sel >= 3'd6));
    chk(ntx == n, tag, ntx, n);
    chk(!addr_bad, "R9", int'(addr_bad), 0);
    if (sel < 3'd6) begin
      for (int i = 0; i < n; i++) begin
        int mi, ti;
        mi = (int'(addr) + i) & 255;
        ti = map * 32 + start + i;
        if (sel[0]) chk(bmem[mi] === {st, exp_tab[ti][6:0]}, tag,
                        int'(bmem[mi]), int'({st, exp_tab[ti][6:0]}));
        else exp_tab[ti] = bmem[mi];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    rst = 1'b1;
    cmd_valid = 1'b0;
    cmd_sel = '0;
    cmd_ctrl = '0;
    cmd_addr = '0;
    status_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && mem_req === 1'b0, "R1",
        int'({busy, done, err, mem_req}), 0);

    // R2: fill every map, then read each back with alternating status bits
    for (int m = 0; m < 8; m++) run_cmd(3'd4, {5'd0, 3'(m)}, 16'(m * 32), 1'b0, 1'b0, "R2");
    for (int m = 0; m < 8; m++) run_cmd(3'd5, {5'd0, 3'(m)}, 16'h4000 + 16'(m * 32), 1'(m), 1'b0, "R2");

    run_cmd(3'd1, {5'd5, 3'd2}, 16'h1234, 1'b0, 1'b0, "R4");
    run_cmd(3'd1, {5'd31, 3'd6}, 16'hFFF0, 1'b1, 1'b0, "R4");
    run_cmd(3'd0, {5'd0, 3'd1}, 16'h0010, 1'b0, 1'b0, "R3");
    run_cmd(3'd0, {5'd7, 3'd1}, 16'h0020, 1'b0, 1'b0, "R3");
    run_cmd(3'd2, {5'd31, 3'd7}, 16'h0080, 1'b0, 1'b0, "R5");
    run_cmd(3'd3, {5'd31, 3'd7}, 16'h0090, 1'b1, 1'b0, "R5");
    run_cmd(3'd4, {5'd31, 3'd0}, 16'h00A0, 1'b0, 1'b0, "R6");
    run_cmd(3'd5, {5'd0, 3'd0}, 16'h00B0, 1'b1, 1'b0, "R6");
    run_cmd(3'd6, {5'd9, 3'd3}, 16'h0000, 1'b0, 1'b0, "R7");
    run_cmd(3'd7, {5'd0, 3'd3}, 16'h0000, 1'b0, 1'b0, "R7");
    // R8: competing command held through the final acknowledge
    run_cmd(3'd0, {5'd10, 3'd4}, 16'h0040, 1'b0, 1'b1, "R8");
    run_cmd(3'd5, {5'd0, 3'd5}, 16'h0060, 1'b0, 1'b0, "R8");
    run_cmd(3'd5, {5'd0, 3'd4}, 16'h0060, 1'b1, 1'b0, "R8");

    for (int k = 0; k < 60; k++) begin
      logic [2:0] s;
      s = 3'($urandom);
      run_cmd(s, 8'($urandom), 16'($urandom), 1'($urandom), 1'b0, tag_of(s));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule